// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block collects one-cycle event pulses from the transmit, receive, bus and PHY logic of a network controller. It holds them in a 32-bit sticky status word and drives one level interrupt line toward the host. Software sees three word registers through a small read/write port: the status word, a per-bit mask, and a global enable. Reading the status word returns the captured events and clears them in the same access. A service routine keeps reading until it gets zero, and a single read at start-up throws away any stale events.

Bit 15 of the status word is not stored. It is derived on every access as the OR of the error and bus-fault group in bits 25 down to 16. The mask only decides which bits can raise the interrupt line. An event whose mask bit is clear is still captured and is still returned by a status read.

Top module: `irq_event_unit`

## Requirements
- R1: After reset the status word, the mask and the enable bit are zero, `irq_o` is low and `reg_rdata_o` is zero.
- R2: A one-cycle pulse on an implemented position of `evt_i` sets that status bit on the next clock edge. The bit stays set until the status word is read. The implemented positions are: 0 rx ok, 1 rx descriptor done, 2 rx error, 3 rx early, 4 rx idle, 5 rx overrun, 6 tx ok, 7 tx descriptor done, 8 tx error, 9 tx idle, 10 tx underrun, 11 statistics service, 12 software, 13 power event, 14 PHY, 16 rx status queue overrun, 20 target abort, 21 master abort, 22 system error, 23 parity error, 24 rx reset done, 25 tx reset done.
- R3: Pulses on `evt_i` bits 15, 17 to 19 and 26 to 31 are ignored. Those bits of the status word always read as zero, apart from bit 15 as defined in R4.
- R4: Bit 15 of a status read equals the OR of status bits 25 to 16. It also takes part in interrupt generation like any other bit.
- R5: A read at byte offset 0x10 returns the status word and clears it. A second read with no events in between returns zero.
- R6: An event that arrives in the same cycle as a status read is not part of that read's data. It is returned by the next status read.
- R7: The mask at offset 0x14 is a read/write register of 32 bits. The enable register at offset 0x18 stores only bit 0, and its other bits read as zero.
- R8: `irq_o` is high exactly when the enable bit is set and some bit of the status word, bit 15 included, is set together with its mask bit. Masked events are still captured in the status word.
- R9: A write to offset 0x10 has no effect. A read of an unmapped offset returns zero and clears nothing.
- R10: Read data is registered. It appears in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one bit per status position |
| reg_addr_i | input | 8 | Register byte offset |
| reg_rd_i | input | 1 | Read strobe, one cycle |
| reg_wr_i | input | 1 | Write strobe, one cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt line |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the very cycle a status read clears the word. The event must miss the current read data and survive the clear. The bench drives the read strobe and an event pulse on the same falling edge. It then shows that the returned data lacks the bit and that the following read holds it. A long random phase mixes reads, mask and enable writes and dense events, so the same collision also occurs many times with other bits set. The summary bit is driven only through the high group, with the mask open on bit 15 alone, so that the line can rise only through the derived bit.

// File: rtl/irq_event_pkg.sv
package irq_event_pkg;
  localparam int unsigned DW = 32;
  // positions that hold a latch; 15 is derived, 17-19 and 26-31 are absent
  localparam logic [DW-1:0] EVT_IMPL = 32'h03F1_7FFF;
  localparam logic [DW-1:0] HI_GRP   = 32'h03FF_0000;
  localparam int unsigned   SUM_BIT  = 15;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_ENABLE
  } reg_sel_e;
endpackage

// File: rtl/irq_status_latch.sv
module irq_status_latch
  import irq_event_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          clr_i,
  output logic [DW-1:0] view_o
);
  logic [DW-1:0] stat_q, stat_d, evt_m;
  logic          sum;

  assign evt_m = evt_i & EVT_IMPL;
  // clear and capture in one edge: new events survive the read
  assign stat_d = (clr_i ? '0 : stat_q) | evt_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign sum = |(stat_q & HI_GRP);

  always_comb begin
    view_o          = stat_q;
    view_o[SUM_BIT] = sum;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_event_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [AW-1:0] OFS_STAT = 8'h10,
  parameter logic [AW-1:0] OFS_MASK = 8'h14,
  parameter logic [AW-1:0] OFS_EN   = 8'h18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] mask_o,
  output logic          en_o,
  output logic          clr_o,
  output logic [DW-1:0] rdata_o
);
  reg_sel_e      sel;
  logic [DW-1:0] mask_q, rdata_q, rd_mux;
  logic          en_q;

  always_comb begin
    if      (addr_i == OFS_STAT) sel = SEL_STATUS;
    else if (addr_i == OFS_MASK) sel = SEL_MASK;
    else if (addr_i == OFS_EN)   sel = SEL_ENABLE;
    else                         sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_mux = status_i;
      SEL_MASK:   rd_mux = mask_q;
      SEL_ENABLE: rd_mux = {{(DW-1){1'b0}}, en_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      en_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_i && sel == SEL_MASK)   mask_q <= wdata_i;
      if (wr_i && sel == SEL_ENABLE) en_q   <= wdata_i[0];
      if (rd_i)                      rdata_q <= rd_mux;
    end
  end

  assign clr_o   = rd_i && (sel == SEL_STATUS);
  assign mask_o  = mask_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import irq_event_pkg::*;
(
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] mask_i,
  input  logic          en_i,
  output logic          irq_o
);
  assign irq_o = en_i && |(status_i & mask_i);
endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit
  import irq_event_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   evt_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_rd_i,
  input  logic          reg_wr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o
);
  logic [DW-1:0] status_view_w, mask_w;
  logic          ie_w, clr_w;

  irq_status_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr_w),
    .view_o (status_view_w)
  );

  irq_ctrl_regs #(.AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .rd_i     (reg_rd_i),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_view_w),
    .mask_o   (mask_w),
    .en_o     (ie_w),
    .clr_o    (clr_w),
    .rdata_o  (reg_rdata_o)
  );

  irq_line_gen u_line (
    .status_i (status_view_w),
    .mask_i   (mask_w),
    .en_i     (ie_w),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/irq_event_unit_chk.sv
module irq_event_unit_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [31:0]   evt_i,
  input logic [AW-1:0] reg_addr_i,
  input logic          reg_rd_i,
  input logic [31:0]   reg_rdata_o,
  input logic          irq_o,
  input logic          ie_w,
  input logic [31:0]   status_view_w
);
  logic rd_st;
  assign rd_st = reg_rd_i && (reg_addr_i == 8'h10);

  assert_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[7] |=> status_view_w[7]);

  assert_unimpl_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |=> (reg_rdata_o[31:26] == 6'd0 && reg_rdata_o[19:17] == 3'd0));

  assert_summary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |=> (reg_rdata_o[15] == |reg_rdata_o[25:16]));

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st && evt_i == 32'd0) ##1 rd_st |=> reg_rdata_o == 32'd0);

  assert_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st && evt_i[0]) ##1 rd_st |=> reg_rdata_o[0]);

  assert_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_w |-> !irq_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

bind irq_event_unit irq_event_unit_chk #(.AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evt_i         (evt_i),
  .reg_addr_i    (reg_addr_i),
  .reg_rd_i      (reg_rd_i),
  .reg_rdata_o   (reg_rdata_o),
  .irq_o         (irq_o),
  .ie_w          (ie_w),
  .status_view_w (status_view_w)
);

// File: tb/irq_event_unit_bench.sv
`timescale 1ns/1ps
module irq_event_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0, wdata = '0;
  logic [7:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_event_unit u_irq_event_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_addr_i(addr),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [31:0] m_stat, m_mask, m_rdata;
  logic        m_ie;

  function automatic bit has_latch(int b);
    return (b <= 14) || (b == 16) || (b >= 20 && b <= 25);
  endfunction

  function automatic logic [31:0] m_view();
    logic [31:0] v = m_stat;
    bit any = 0;
    for (int b = 16; b <= 25; b++) if (m_stat[b]) any = 1;
    v[15] = any;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_rdata = 0; m_ie = 0;
    end else begin
      if (rd) begin
        if (addr == 8'h10)      m_rdata = m_view();
        else if (addr == 8'h14) m_rdata = m_mask;
        else if (addr == 8'h18) m_rdata = {31'd0, m_ie};
        else                    m_rdata = 0;
      end
      if (wr && addr == 8'h14) m_mask = wdata;
      if (wr && addr == 8'h18) m_ie = wdata[0];
      if (rd && addr == 8'h10) m_stat = 0;
      for (int b = 0; b < 32; b++) if (evt[b] && has_latch(b)) m_stat[b] = 1'b1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R8 irq vs model", {31'd0, irq}, {31'd0, m_ie && ((m_view() & m_mask) != 0)});
    chk("R10 rdata vs model", rdata, m_rdata);
  end

  task automatic step(); @(negedge clk); endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd = 1; step(); rd = 0; evt = 0; d = rdata;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1; step(); wr = 0;
  endtask

  task automatic pulse(input logic [31:0] e);
    evt = e; step(); evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) step();
    chk("R1 rdata in reset", rdata, 0);
    chk("R1 irq in reset", {31'd0, irq}, 0);
    rst_n = 1; step();
    rd_reg(8'h10, d); chk("R1 status after reset", d, 0);
    rd_reg(8'h14, d); chk("R1 mask after reset", d, 0);
    rd_reg(8'h18, d); chk("R1 enable after reset", d, 0);

    // R2 / R4 / R5
    pulse(32'h0001_4001); step(); step();
    rd_reg(8'h10, d); chk("R2 R4 latched bits and summary", d, 32'h0001_C001);
    rd_reg(8'h10, d); chk("R5 second read zero", d, 0);

    // R3 all positions
    pulse(32'hFFFF_FFFF);
    rd_reg(8'h10, d); chk("R3 only implemented bits", d, 32'h03F1_FFFF);

    // R6 collision
    addr = 8'h10; rd = 1; evt = 32'h0000_0040; step(); rd = 0; evt = 0;
    chk("R6 colliding event absent", rdata, 0);
    rd_reg(8'h10, d); chk("R6 colliding event kept", d, 32'h0000_0040);

    // R7
    wr_reg(8'h14, 32'hA5A5_F00F); rd_reg(8'h14, d); chk("R7 mask readback", d, 32'hA5A5_F00F);
    wr_reg(8'h18, 32'hFFFF_FFFE); rd_reg(8'h18, d); chk("R7 enable bit0 only clear", d, 0);
    wr_reg(8'h18, 32'hFFFF_FFFF); rd_reg(8'h18, d); chk("R7 enable bit0 only", d, 1);

    // R8
    wr_reg(8'h18, 0); wr_reg(8'h14, 32'hFFFF_FFFF);
    pulse(32'h0000_0200); chk("R8 disabled no irq", {31'd0, irq}, 0);
    wr_reg(8'h18, 1); chk("R8 enabled irq", {31'd0, irq}, 1);
    wr_reg(8'h14, 0); chk("R8 masked no irq", {31'd0, irq}, 0);
    rd_reg(8'h10, d); chk("R8 masked still latched", d, 32'h0000_0200);

    // R4 via line
    wr_reg(8'h14, 32'h0000_8000);
    pulse(32'h0040_0000); chk("R4 summary raises irq", {31'd0, irq}, 1);
    rd_reg(8'h10, d); chk("R4 summary read", d, 32'h0040_8000);
    chk("R8 irq drops after read", {31'd0, irq}, 0);

    // R9
    pulse(32'h0000_0008);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_reg(8'h20, d); chk("R9 unmapped reads zero", d, 0);
    rd_reg(8'h10, d); chk("R9 status untouched", d, 32'h0000_0008);

    // R10 hold
    pulse(32'h0000_0001); step(); pulse(32'h0000_0002);
    chk("R10 rdata held", rdata, 32'h0000_0008);

    // random phase
    for (int i = 0; i < 2000; i++) begin
      evt = $urandom() & $urandom();
      case ($urandom_range(0, 3))
        0: addr = 8'h10; 1: addr = 8'h14; 2: addr = 8'h18; default: addr = 8'h1C;
      endcase
      rd = ($urandom_range(0, 2) == 0);
      wr = ($urandom_range(0, 4) == 0);
      wdata = $urandom();
      step();
    end
    rd = 0; wr = 0; evt = 0; step();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule